// File: doc/BRIEF.md
# Receive Descriptor Filler

This block sits behind a serial receiver and moves each incoming frame into memory. Frames come in as a stream of bytes. The final byte of a frame carries an end marker, and it may also carry an error marker. Software provides a ring of 8-byte descriptors. Each descriptor has a status halfword, a length halfword and a buffer pointer. Software hands a descriptor to the block by setting its empty bit. The block takes descriptors in ring order and fills each buffer with at most `mrblr` bytes. A buffer is closed when it is full or when its frame ends. On close, the block writes the length halfword first and the status halfword second.

A frame longer than one buffer is spread over several descriptors. Every descriptor of a frame except the last reports the full buffer length. The descriptor that ends the frame reports the total number of bytes in the frame, counted across all of its buffers. Sometimes a frame ends exactly at a buffer boundary. The block then opens one more descriptor, stores no data in it, and closes it only to report the frame total and the end-of-frame flag.

The block pulses `rxf_irq` once for each frame that completes. It may need a descriptor that software has not yet handed back. In that case it pulses `ovr_evt` and discards the rest of that frame. The next frame starts at that same descriptor.

Top module: `rxbd_filler`

## Requirements
- R1: While reset is held and in the first cycle after it, `rx_ready`, `mem_req`, `rxf_irq` and `ovr_evt` are all 0.
- R2: A descriptor is laid out as follows: byte offset 0 holds the status, offset 2 holds the length, and offset 4 holds the buffer pointer. The bytes of a buffer go to consecutive byte addresses starting at the pointer. Byte address a uses lane a[0] of the 16-bit data bus, with lane 0 in bits 7:0.
- R3: A buffer never holds more than `mrblr` bytes. A buffer that closes because it is full, and that does not end the frame, reports a length equal to `mrblr` and has bit 11 of its status clear.
- R4: The descriptor that ends a frame has status bit 11 set. Its length field is the total byte count of the whole frame.
- R5: A frame may end exactly when a buffer fills. That buffer is then closed as not last. The next descriptor is opened and closed with no data written, with bit 11 set and the frame total as its length.
- R6: When a descriptor closes, the length halfword is written in the cycle just before the status halfword.
- R7: If a frame's end byte also carries the error marker, status bit 1 is set in that frame's last descriptor. Descriptors that are not last always have bit 1 clear.
- R8: When the block needs a new descriptor and finds bit 15 (empty) clear, it pulses `ovr_evt` for one cycle. It writes nothing to memory, consumes the remaining bytes of the frame without storing them, and raises no interrupt. The same descriptor is polled again when the next frame arrives.
- R9: Status bit 13 (wrap) is kept in the written status. After a descriptor with that bit set, the block continues at `ring_base`. After any other descriptor it continues 8 bytes further on.
- R10: `rxf_irq` is a single-cycle pulse. It occurs once per completed frame, in the cycle after the last descriptor's status is written.
- R11: A written status has bit 15 clear. Only bits 13, 11 and 1 can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Byte address of the first descriptor of the ring |
| mrblr | input | 16 | Maximum bytes per receive buffer (nonzero) |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the final one of its frame |
| rx_err | input | 1 | Frame error marker, valid with `rx_last` |
| rx_ready | output | 1 | Byte is taken on this clock edge when `rx_valid` is high |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_be | output | 2 | Byte lane enables for writes |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| rxf_irq | output | 1 | Frame received pulse |
| ovr_evt | output | 1 | Descriptor unavailable pulse; frame discarded |

## Verification
The bench uses a 4-byte buffer limit. It sends frames shorter than one buffer, frames that span several buffers, and a frame whose length is an exact multiple of the buffer size. If a design handled the exact-multiple case wrongly, it would mark the full buffer as last, or it would skip the empty extra descriptor. The bench would then see a missing or wrong frame total. If a design reported only the bytes in the final buffer, the bench would see a length shorter than the frame. Further scenarios send an errored frame into the wrapping descriptor and then a frame into a descriptor that is still owned by software. A design that stored the discarded bytes, skipped the unavailable descriptor, or cleared the wrap bit would leave buffer contents or descriptor addresses different from those the bench expects.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // status halfword bit positions
  localparam int unsigned ST_EMPTY = 15;
  localparam int unsigned ST_WRAP  = 13;
  localparam int unsigned ST_LAST  = 11;
  localparam int unsigned ST_ERR   = 1;

  // descriptor field byte offsets
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_LEN  = 2;
  localparam int unsigned OFF_PTR  = 4;
  localparam int unsigned BD_BYTES = 8;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_STAT,
    OP_RD_PTR,
    OP_WR_BYTE,
    OP_WR_LEN,
    OP_WR_STAT
  } mem_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN_ST,
    S_OPEN_STW,
    S_OPEN_PTR,
    S_OPEN_PTRW,
    S_RUN,
    S_CL_LEN,
    S_CL_ST
  } fill_st_e;

  // length reported on close: whole frame for the final descriptor
  function automatic logic [15:0] close_len(input logic last,
                                            input logic [15:0] cnt,
                                            input logic [15:0] tot);
    return last ? tot : cnt;
  endfunction

  // status written back on close: empty cleared, wrap kept
  function automatic logic [15:0] close_stat(input logic wrap,
                                             input logic last,
                                             input logic err);
    logic [15:0] s;
    s          = '0;
    s[ST_WRAP] = wrap;
    s[ST_LAST] = last;
    s[ST_ERR]  = err & last;
    return s;
  endfunction

  // byte lane enable for a byte address
  function automatic logic [1:0] lane_of(input logic a0);
    return a0 ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] bd_addr
);
  localparam logic [AW-1:0] STEP = AW'(rxbd_pkg::BD_BYTES);

  logic [AW-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       off_q <= '0;
    else if (advance) off_q <= wrap ? '0 : off_q + STEP;
  end

  assign bd_addr = ring_base + off_q;
endmodule

// File: rtl/rxbd_buf_track.sv
module rxbd_buf_track #(
  parameter int unsigned LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_buf,
  input  logic          accept,
  input  logic          frame_done,
  input  logic [LW-1:0] mrblr,
  output logic [LW-1:0] cnt,
  output logic [LW-1:0] tot,
  output logic          fill_now
);
  localparam logic [LW-1:0] ONE = LW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tot <= '0;
    end else begin
      if (open_buf)    cnt <= '0;
      else if (accept) cnt <= cnt + ONE;
      if (frame_done)  tot <= '0;
      else if (accept) tot <= tot + ONE;
    end
  end

  assign fill_now = (cnt + ONE) == mrblr;
endmodule

// File: rtl/rxbd_mem_cmd.sv
module rxbd_mem_cmd import rxbd_pkg::*; #(
  parameter int unsigned AW = 16
) (
  input  mem_op_e       op,
  input  logic [AW-1:0] bd_addr,
  input  logic [AW-1:0] buf_ptr,
  input  logic [15:0]   cnt,
  input  logic [7:0]    byte_in,
  input  logic [15:0]   len_val,
  input  logic [15:0]   stat_val,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata
);
  logic [AW-1:0] byte_addr;
  assign byte_addr = buf_ptr + AW'(cnt);

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_be    = 2'b11;
    mem_addr  = bd_addr;
    mem_wdata = '0;
    case (op)
      OP_RD_STAT: mem_addr = bd_addr + AW'(OFF_STAT);
      OP_RD_PTR:  mem_addr = bd_addr + AW'(OFF_PTR);
      OP_WR_BYTE: begin
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_be    = lane_of(byte_addr[0]);
        mem_wdata = {byte_in, byte_in};
      end
      OP_WR_LEN: begin
        mem_we    = 1'b1;
        mem_addr  = bd_addr + AW'(OFF_LEN);
        mem_wdata = len_val;
      end
      OP_WR_STAT: begin
        mem_we    = 1'b1;
        mem_addr  = bd_addr + AW'(OFF_STAT);
        mem_wdata = stat_val;
      end
      default: begin
        mem_req = 1'b0;
        mem_be  = 2'b00;
      end
    endcase
  end
endmodule

// File: rtl/rxbd_filler.sv
module rxbd_filler import rxbd_pkg::*; #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   mrblr,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_err,
  output logic          rx_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          rxf_irq,
  output logic          ovr_evt
);
  fill_st_e      state_q, state_d;
  mem_op_e       op;
  logic [AW-1:0] bd_addr, buf_ptr_q;
  logic          wrap_q, last_q, err_q, pend_q, drop_q, irq_q, ovr_q;
  logic [15:0]   cnt, tot, len_val, stat_val;
  logic          fill_now;

  // named internal events
  logic ev_accept, ev_drop, ev_ovr, ev_open, ev_wr_len, ev_wr_stat;
  logic ev_close_last, ev_advance, ev_frame_done;

  assign rx_ready      = (state_q == S_RUN) || (state_q == S_IDLE && drop_q);
  assign ev_accept     = (state_q == S_RUN) && rx_valid;
  assign ev_drop       = (state_q == S_IDLE) && drop_q && rx_valid;
  assign ev_ovr        = (state_q == S_OPEN_STW) && !mem_rdata[ST_EMPTY];
  assign ev_open       = (state_q == S_OPEN_PTRW);
  assign ev_wr_len     = (state_q == S_CL_LEN);
  assign ev_wr_stat    = (state_q == S_CL_ST);
  assign ev_close_last = ev_wr_stat && last_q;
  assign ev_advance    = ev_wr_stat;
  assign ev_frame_done = ev_close_last || ev_ovr;

  assign len_val  = close_len(last_q, cnt, tot);
  assign stat_val = close_stat(wrap_q, last_q, err_q);

  rxbd_ring_ptr #(.AW(AW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .advance   (ev_advance),
    .wrap      (wrap_q),
    .bd_addr   (bd_addr)
  );

  rxbd_buf_track #(.LW(16)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_buf   (ev_open),
    .accept     (ev_accept),
    .frame_done (ev_frame_done),
    .mrblr      (mrblr),
    .cnt        (cnt),
    .tot        (tot),
    .fill_now   (fill_now)
  );

  always_comb begin
    case (state_q)
      S_OPEN_ST:  op = OP_RD_STAT;
      S_OPEN_PTR: op = OP_RD_PTR;
      S_RUN:      op = rx_valid ? OP_WR_BYTE : OP_NONE;
      S_CL_LEN:   op = OP_WR_LEN;
      S_CL_ST:    op = OP_WR_STAT;
      default:    op = OP_NONE;
    endcase
  end

  rxbd_mem_cmd #(.AW(AW)) u_cmd (
    .op        (op),
    .bd_addr   (bd_addr),
    .buf_ptr   (buf_ptr_q),
    .cnt       (cnt),
    .byte_in   (rx_data),
    .len_val   (len_val),
    .stat_val  (stat_val),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:      if (rx_valid && !drop_q) state_d = S_OPEN_ST;
      S_OPEN_ST:   state_d = S_OPEN_STW;
      S_OPEN_STW:  state_d = ev_ovr ? S_IDLE : S_OPEN_PTR;
      S_OPEN_PTR:  state_d = S_OPEN_PTRW;
      S_OPEN_PTRW: state_d = pend_q ? S_CL_LEN : S_RUN;
      S_RUN:       if (rx_valid && (fill_now || rx_last)) state_d = S_CL_LEN;
      S_CL_LEN:    state_d = S_CL_ST;
      S_CL_ST:     state_d = (pend_q && !last_q) ? S_OPEN_ST : S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      buf_ptr_q <= '0;
      wrap_q    <= 1'b0;
      last_q    <= 1'b0;
      err_q     <= 1'b0;
      pend_q    <= 1'b0;
      drop_q    <= 1'b0;
      irq_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= ev_close_last;
      ovr_q   <= ev_ovr;
      if (ev_drop && rx_last) drop_q <= 1'b0;
      case (state_q)
        S_OPEN_STW: begin
          if (ev_ovr) begin
            drop_q <= !pend_q;
            pend_q <= 1'b0;
          end else begin
            wrap_q <= mem_rdata[ST_WRAP];
          end
        end
        S_OPEN_PTRW: begin
          buf_ptr_q <= AW'(mem_rdata);
          last_q    <= pend_q;
        end
        S_RUN: begin
          if (rx_valid && fill_now) begin
            last_q <= 1'b0;
            pend_q <= rx_last;
            err_q  <= rx_err && rx_last;
          end else if (rx_valid && rx_last) begin
            last_q <= 1'b1;
            err_q  <= rx_err;
          end
        end
        S_CL_ST: if (last_q) pend_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign rxf_irq = irq_q;
  assign ovr_evt = ovr_q;
endmodule

// File: rtl/rxbd_filler_chk.sv
module rxbd_filler_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rxf_irq,
  input logic          ovr_evt,
  input logic          mem_req,
  input logic          mem_we,
  input logic          ev_accept,
  input logic          ev_wr_len,
  input logic          ev_wr_stat,
  input logic          ev_close_last,
  input logic          ev_advance,
  input logic          bd_wrap,
  input logic [AW-1:0] bd_addr,
  input logic [AW-1:0] ring_base,
  input logic [15:0]   buf_cnt,
  input logic [15:0]   mrblr
);
  p_len_then_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_stat |-> $past(ev_wr_len));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (buf_cnt < mrblr));

  p_accept_stores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (mem_req && mem_we));

  p_irq_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_irq |-> $past(ev_close_last));

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_irq |=> !rxf_irq);

  p_wrap_to_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_advance && bd_wrap) |=> (bd_addr == ring_base));

  p_ovr_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> !(mem_req && mem_we));

  p_drop_no_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !ev_accept) |-> !mem_req);
endmodule

bind rxbd_filler rxbd_filler_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid      (rx_valid),
  .rx_ready      (rx_ready),
  .rxf_irq       (rxf_irq),
  .ovr_evt       (ovr_evt),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .ev_accept     (ev_accept),
  .ev_wr_len     (ev_wr_len),
  .ev_wr_stat    (ev_wr_stat),
  .ev_close_last (ev_close_last),
  .ev_advance    (ev_advance),
  .bd_wrap       (wrap_q),
  .bd_addr       (bd_addr),
  .ring_base     (ring_base),
  .buf_cnt       (cnt),
  .mrblr         (mrblr)
);

// File: tb/sim_rxbd_filler.sv
`timescale 1ns/1ps
module sim_rxbd_filler;
  localparam int AW = 16;
  localparam logic [15:0] RING = 16'h0100;
  localparam logic [15:0] BUFB = 16'h0200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = RING;
  logic [15:0]   mrblr = 16'd4;
  logic          rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, mem_req, mem_we, rxf_irq, ovr_evt;
  logic [1:0]    mem_be;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [15:0]   rdata_q = '0;

  int checks = 0, errors = 0;
  int cyc = 0, irq_cnt = 0, ovr_cnt = 0, data_wr = 0;
  int len_t [0:7];
  int stat_t[0:7];
  logic [15:0] mem [0:1023];

  always #5 clk = ~clk;

  rxbd_filler #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .mrblr(mrblr),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
    .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_q),
    .rxf_irq(rxf_irq), .ovr_evt(ovr_evt)
  );

  // memory model, one cycle read latency
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rxf_irq) irq_cnt = irq_cnt + 1;
    if (ovr_evt) ovr_cnt = ovr_cnt + 1;
    if (mem_req) begin
      if (mem_we) begin
        if (mem_be[0]) mem[mem_addr[10:1]][7:0]  = mem_wdata[7:0];
        if (mem_be[1]) mem[mem_addr[10:1]][15:8] = mem_wdata[15:8];
        if (mem_addr >= BUFB) data_wr = data_wr + 1;
        else if (mem_addr >= RING && mem_addr < RING + 16'd64) begin
          if (mem_addr[2:0] == 3'd2) len_t[(mem_addr - RING) >> 3] = cyc;
          if (mem_addr[2:0] == 3'd0) stat_t[(mem_addr - RING) >> 3] = cyc;
        end
      end else begin
        rdata_q = mem[mem_addr[10:1]];
      end
    end
  end

  function automatic logic [15:0] rd16(input logic [15:0] a);
    return mem[a[10:1]];
  endfunction
  function automatic logic [7:0] rdb(input logic [15:0] a);
    return a[0] ? mem[a[10:1]][15:8] : mem[a[10:1]][7:0];
  endfunction
  function automatic logic [15:0] bd(input int i);
    return RING + 16'(8 * i);
  endfunction
  function automatic logic [15:0] bufp(input int i);
    return BUFB + 16'(16 * i);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic arm(input int i, input bit wrap);
    mem[bd(i) >> 1]        = 16'h8000 | (wrap ? 16'h2000 : 16'h0000);
    mem[(bd(i) + 2) >> 1]  = 16'h0000;
    mem[(bd(i) + 4) >> 1]  = bufp(i);
    for (int k = 0; k < 8; k++) mem[(bufp(i) >> 1) + k] = 16'hEEEE;
  endtask

  task automatic push(input logic [7:0] d, input bit last, input bit err);
    rx_valid = 1'b1; rx_data = d; rx_last = last; rx_err = err;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
  endtask

  task automatic send(input int n, input logic [7:0] seed, input bit err);
    for (int j = 0; j < n; j++) push(seed + 8'(j), j == n - 1, err && j == n - 1);
    repeat (16) @(negedge clk);
  endtask

  task automatic check_bd(input int i, input logic [15:0] st, input logic [15:0] ln, input string req);
    chk(rd16(bd(i)) == st, {req, " status"}, rd16(bd(i)), st);
    chk(rd16(bd(i) + 2) == ln, {req, " length"}, rd16(bd(i) + 2), ln);
  endtask

  task automatic t_reset;
    // R1: quiet outputs during and just after reset
    chk(rx_ready == 0 && mem_req == 0 && rxf_irq == 0 && ovr_evt == 0, "R1 in reset",
        {rx_ready, mem_req, rxf_irq, ovr_evt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_ready == 0 && mem_req == 0 && rxf_irq == 0 && ovr_evt == 0, "R1 after reset",
        {rx_ready, mem_req, rxf_irq, ovr_evt}, 0);
  endtask

  task automatic t_short;
    int i0 = irq_cnt;
    send(3, 8'h10, 1'b0);
    check_bd(0, 16'h0800, 16'd3, "R4 short frame");
    for (int j = 0; j < 3; j++)
      chk(rdb(bufp(0) + 16'(j)) == 8'h10 + 8'(j), "R2 byte placement", rdb(bufp(0) + 16'(j)), 8'h10 + 8'(j));
    chk(irq_cnt - i0 == 1, "R10 one irq per frame", irq_cnt - i0, 1);
  endtask

  task automatic t_multi;
    int i0 = irq_cnt;
    send(10, 8'h20, 1'b0);
    check_bd(1, 16'h0000, 16'd4, "R3 full buffer");
    check_bd(2, 16'h0000, 16'd4, "R3 full buffer");
    check_bd(3, 16'h0800, 16'd10, "R4 frame total");
    chk(rdb(bufp(2) + 16'd3) == 8'h27, "R2 second buffer", rdb(bufp(2) + 16'd3), 8'h27);
    chk(rdb(bufp(3) + 16'd1) == 8'h29, "R2 last buffer", rdb(bufp(3) + 16'd1), 8'h29);
    chk(rdb(bufp(3) + 16'd2) == 8'hEE, "R3 no byte past end", rdb(bufp(3) + 16'd2), 8'hEE);
    chk(irq_cnt - i0 == 1, "R10 one irq multi", irq_cnt - i0, 1);
  endtask

  task automatic t_exact;
    int d0 = data_wr;
    send(8, 8'h40, 1'b0);
    check_bd(4, 16'h0000, 16'd4, "R5 first full");
    check_bd(5, 16'h0000, 16'd4, "R5 boundary buffer not last");
    check_bd(6, 16'h0800, 16'd8, "R5 extra descriptor");
    chk(rd16(bufp(6)) == 16'hEEEE, "R5 extra holds no data", rd16(bufp(6)), 16'hEEEE);
    chk(data_wr - d0 == 8, "R5 byte writes", data_wr - d0, 8);
  endtask

  task automatic t_err_wrap;
    send(2, 8'h50, 1'b1);
    check_bd(7, 16'h2802, 16'd2, "R7 R11 error in wrapping last");
    arm(0, 1'b0);
    send(1, 8'h60, 1'b0);
    check_bd(0, 16'h0800, 16'd1, "R9 wrapped to base");
    chk(rdb(bufp(0)) == 8'h60, "R9 data at base descriptor", rdb(bufp(0)), 8'h60);
  endtask

  task automatic t_overrun;
    int i0 = irq_cnt, o0 = ovr_cnt, d0 = data_wr;
    send(3, 8'h70, 1'b0);
    chk(ovr_cnt - o0 == 1, "R8 overrun pulse", ovr_cnt - o0, 1);
    chk(irq_cnt == i0, "R8 no irq", irq_cnt - i0, 0);
    chk(data_wr == d0, "R8 nothing stored", data_wr - d0, 0);
    check_bd(1, 16'h0000, 16'd4, "R8 descriptor untouched");
    arm(1, 1'b0);
    send(2, 8'h80, 1'b0);
    check_bd(1, 16'h0800, 16'd2, "R8 same descriptor retried");
    chk(rdb(bufp(1)) == 8'h80, "R8 retried data", rdb(bufp(1)), 8'h80);
  endtask

  task automatic t_order;
    for (int i = 0; i < 8; i++)
      chk(stat_t[i] == len_t[i] + 1, "R6 length before status", stat_t[i], len_t[i] + 1);
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 16'h0000;
    for (int i = 0; i < 8; i++) begin len_t[i] = 0; stat_t[i] = 0; arm(i, i == 7); end
    repeat (3) @(negedge clk);
    t_reset;
    t_short;
    t_multi;
    t_exact;
    t_err_wrap;
    t_overrun;
    t_order;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule